// File: doc/BRIEF.md
# APB GPIO Controller with Pin Interrupts

This block is a general-purpose I/O peripheral on an APB bus. It has up to four ports, each a parameterised number of pins wide. Every port has an output-data register and a direction register, which drive the pin output and output-enable vectors. Every port also has a read-only view of its pins. That view is taken after a two-flop synchronizer, so software always reads settled values.

Only the first port (port 0) can raise interrupts. Each of its pins can be enabled, masked, set to level or edge sensitivity, and set to a chosen polarity. Edge events stay latched until software writes a 1 to that pin's bit in the end-of-interrupt register. A level interrupt follows the pin. Edges are found by comparing two successive synchronized samples. Software can therefore flip a pin's polarity after each event to catch both edges, and the flip alone never counts as an event. All enabled, unmasked pending bits are ORed onto one interrupt line.

Top module: `gpio_apb_irq`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: The output-data register of port p sits at offset 12*p and its direction register at 12*p+4. They read back what was written, `pin_out` carries the data bits and `pin_oe` carries the direction bits (1 = drive).
- R3: Offset 0x50+4*p returns the levels on port p's pins after the two-flop synchronizer.
- R4: When a bit of the type register (0x38) is 1, that pin is level-sensitive. The pin is pending while its level equals its polarity bit in 0x3c (1 = high, 0 = low). This pending state is not latched, so end-of-interrupt has no effect on it.
- R5: When a type bit is 0, that pin is edge-sensitive. Polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. The latched bit stays set after the pin returns to its old level.
- R6: Writing to offset 0x4c clears each latched edge bit whose write bit is 1. Write bits that are 0 leave their latched bits unchanged.
- R7: A 1 in the mask register (0x34) hides that pin from the status register and from `irq`. An edge that arrives while the pin is masked is still latched, and it appears once the mask bit is cleared.
- R8: A pin whose bit in the enable register (0x30) is 0 never appears in status and never drives `irq`.
- R9: Changing a polarity bit while the pin is steady creates no edge event.
- R10: Pins of ports 1 to 3 never affect the status register or `irq`.
- R11: Reads of unmapped offsets, and reads of the write-only offset 0x4c, return zero. `pready` is always 1 and `pslverr` is always 0.
- R12: The status register (0x40) holds the enabled, unmasked pending bits, and `irq` is high while any of them is set. Clearing one pending bit leaves `irq` high if others remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| pin_in | input | NUM_PORTS*PORT_W | Pin levels, port p at bits p*PORT_W upward |
| pin_out | output | NUM_PORTS*PORT_W | Output data per pin |
| pin_oe | output | NUM_PORTS*PORT_W | Output enable per pin |
| irq | output | 1 | Combined port-0 interrupt |

## Verification
The bench targets the cases where interrupt state can outlive or outrun its cause, and checks the bad behaviour each one would expose:
- An edge latch that tracked the pin would drop the pending bit as soon as the pin returned to its old level.
- End-of-interrupt logic that ignored the write data, or cleared on write-0, would wipe unrelated pending bits.
- An edge detector built on polarity instead of on successive samples would report a false event when polarity is flipped while the pin is steady.
- A mask that gated the latch itself, rather than the status, would lose an edge that arrived while the pin was masked.
- Wrong decoding would let other ports' pins fire interrupts, or let a level interrupt be cleared by end-of-interrupt.

// File: rtl/gpio_apb_irq.sv
module gpio_apb_irq #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  output logic                        irq
);
  localparam int NP = NUM_PORTS * PORT_W;
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(8'h3c);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(8'h4c);
  localparam int A_EXT = 8'h50;

  logic [NP-1:0] dout_q, dir_q, sync1_q, sync2_q;
  logic [PORT_W-1:0] prev_q, en_q, mask_q, type_q, pol_q, latch_q;
  logic [PORT_W-1:0] pa, rise, fall, edge_hit, eoi_clr, lvl_act, raw, status;
  logic wr, eoi_wr;

  assign wr      = psel & penable & pwrite;
  assign eoi_wr  = wr && (paddr == A_EOI);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      dout_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (paddr == ADDR_W'(12*p))     dout_q[p*PORT_W +: PORT_W] <= pwdata[PORT_W-1:0];
        if (paddr == ADDR_W'(12*p + 4)) dir_q[p*PORT_W +: PORT_W]  <= pwdata[PORT_W-1:0];
      end
      if (paddr == A_EN)   en_q   <= pwdata[PORT_W-1:0];
      if (paddr == A_MASK) mask_q <= pwdata[PORT_W-1:0];
      if (paddr == A_TYPE) type_q <= pwdata[PORT_W-1:0];
      if (paddr == A_POL)  pol_q  <= pwdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= pa;
      latch_q <= (latch_q & ~eoi_clr) | edge_hit;
    end
  end

  assign pa       = sync2_q[PORT_W-1:0];
  assign rise     = pa & ~prev_q;
  assign fall     = ~pa & prev_q;
  assign edge_hit = en_q & ~type_q & ((pol_q & rise) | (~pol_q & fall));
  assign eoi_clr  = eoi_wr ? pwdata[PORT_W-1:0] : '0;
  assign lvl_act  = ~(pa ^ pol_q);
  assign raw      = (type_q & lvl_act) | (~type_q & latch_q);
  assign status   = raw & en_q & ~mask_q;
  assign irq      = |status;

  always_comb begin
    prdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (paddr == ADDR_W'(12*p))        prdata = 32'(dout_q[p*PORT_W +: PORT_W]);
      if (paddr == ADDR_W'(12*p + 4))    prdata = 32'(dir_q[p*PORT_W +: PORT_W]);
      if (paddr == ADDR_W'(A_EXT + 4*p)) prdata = 32'(sync2_q[p*PORT_W +: PORT_W]);
    end
    case (paddr)
      A_EN:    prdata = 32'(en_q);
      A_MASK:  prdata = 32'(mask_q);
      A_TYPE:  prdata = 32'(type_q);
      A_POL:   prdata = 32'(pol_q);
      A_STAT:  prdata = 32'(status);
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_apb_irq_chk.sv
module gpio_apb_irq_chk #(
  parameter int NP     = 32,
  parameter int PORT_W = 8
) (
  input logic              pclk,
  input logic              presetn,
  input logic              irq,
  input logic [NP-1:0]     pin_oe,
  input logic              eoi_wr,
  input logic [31:0]       pwdata,
  input logic [PORT_W-1:0] latch_q,
  input logic [PORT_W-1:0] edge_hit,
  input logic [PORT_W-1:0] pa,
  input logic [PORT_W-1:0] prev_q,
  input logic [PORT_W-1:0] en_q,
  input logic [PORT_W-1:0] mask_q
);
  always @(posedge pclk) begin
    if (!presetn) begin
      p_reset_quiet_r1: assert (pin_oe == '0 && !irq);
    end
  end

  p_eoi_clears_r6: assert property (@(posedge pclk) disable iff (!presetn)
    eoi_wr |=> ((latch_q & $past(pwdata[PORT_W-1:0] & ~edge_hit)) == '0));

  p_latch_holds_r5: assert property (@(posedge pclk) disable iff (!presetn)
    !eoi_wr |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  p_no_false_edge_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (pa == prev_q) |=> ((latch_q & ~$past(latch_q)) == '0));

  p_masked_quiet_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (mask_q == '1) |-> !irq);

  p_disabled_quiet_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (en_q == '0) |-> !irq);
endmodule

bind gpio_apb_irq gpio_apb_irq_chk #(.NP(NP), .PORT_W(PORT_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .irq(irq), .pin_oe(pin_oe),
  .eoi_wr(eoi_wr), .pwdata(pwdata), .latch_q(latch_q), .edge_hit(edge_hit),
  .pa(pa), .prev_q(prev_q), .en_q(en_q), .mask_q(mask_q)
);

// File: tb/tb_gpio_apb_irq.sv
module tb_gpio_apb_irq;
  logic clk = 0, rstn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq;
  logic [31:0] pins = '0, pout, poe;

  gpio_apb_irq dut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq(irq)
  );

  always #5 clk = ~clk;

  logic [31:0] exp_q[$], act_q[$];
  string tag_q[$];
  int nvec = 0, nfail = 0;
  bit done = 0;

  initial begin
    forever begin
      wait (act_q.size() != 0);
      begin
        logic [31:0] a, e;
        string t;
        a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        nvec++;
        if (a !== e) begin
          nfail++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); act_q.push_back(a);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 push(prdata, e, t);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic sig(input logic [31:0] a, input logic [31:0] e, input string t);
    push(a, e, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstn = 1;
    @(negedge clk);
    // R1 reset state
    sig(poe, 0, "R1 pin_oe");
    sig(pout, 0, "R1 pin_out");
    sig(32'(irq), 0, "R1 irq");
    rd(8'h00, 0, "R1 data A");
    rd(8'h04, 0, "R1 dir A");
    rd(8'h30, 0, "R1 enable");
    rd(8'h3c, 0, "R1 polarity");
    rd(8'h40, 0, "R1 status");

    // R2 per-port data and direction
    for (int p = 0; p < 4; p++) begin
      wr(8'(12*p), 32'hA0 + p);
      wr(8'(12*p + 4), 32'h0F + 16*p);
    end
    for (int p = 0; p < 4; p++) begin
      rd(8'(12*p), 32'hA0 + p, "R2 data readback");
      rd(8'(12*p + 4), 32'h0F + 16*p, "R2 dir readback");
    end
    @(negedge clk);
    sig(pout, 32'hA3A2A1A0, "R2 pin_out");
    sig(poe, 32'h3F2F1F0F, "R2 pin_oe");

    // R3 synchronized pin view
    pins = 32'h11223344;
    settle();
    rd(8'h50, 32'h44, "R3 ext port0");
    rd(8'h54, 32'h33, "R3 ext port1");
    rd(8'h58, 32'h22, "R3 ext port2");
    rd(8'h5c, 32'h11, "R3 ext port3");
    pins = 0;
    settle();

    // R8 disabled pin stays quiet
    wr(8'h3c, 32'hFF);
    pins[0] = 1; settle();
    sig(32'(irq), 0, "R8 irq with enable off");
    rd(8'h40, 0, "R8 status with enable off");
    pins[0] = 0; settle();

    // R5 edge latching, R6 end-of-interrupt
    wr(8'h30, 32'hFF);
    wr(8'h3c, 32'h01);
    pins[0] = 1; settle();
    sig(32'(irq), 1, "R5 rising edge irq");
    rd(8'h40, 32'h01, "R5 rising edge status");
    pins[0] = 0; settle();
    rd(8'h40, 32'h01, "R5 latched after pin returns");
    wr(8'h4c, 32'h00);
    rd(8'h40, 32'h01, "R6 eoi zero no effect");
    wr(8'h4c, 32'h02);
    rd(8'h40, 32'h01, "R6 eoi other bit no effect");
    wr(8'h4c, 32'h01);
    rd(8'h40, 32'h00, "R6 eoi clears");
    @(negedge clk);
    sig(32'(irq), 0, "R6 irq after eoi");
    pins[1] = 1; settle();
    rd(8'h40, 32'h00, "R5 rising ignored on falling pin");
    pins[1] = 0; settle();
    rd(8'h40, 32'h02, "R5 falling edge latched");
    wr(8'h4c, 32'h02);

    // R9 polarity flip alone
    wr(8'h3c, 32'h00);
    settle();
    rd(8'h40, 32'h00, "R9 polarity flip to falling");
    pins[2] = 1; settle();
    wr(8'h3c, 32'h04);
    settle();
    rd(8'h40, 32'h00, "R9 polarity flip with pin high");
    pins[2] = 0; settle();
    wr(8'h3c, 32'h00);
    settle();
    rd(8'h40, 32'h00, "R9 flip back");

    // R7 mask keeps latch
    wr(8'h3c, 32'hFF);
    wr(8'h34, 32'h01);
    pins[0] = 1; settle();
    sig(32'(irq), 0, "R7 masked irq");
    rd(8'h40, 32'h00, "R7 masked status");
    wr(8'h34, 32'h00);
    rd(8'h40, 32'h01, "R7 unmasked reveals latch");
    @(negedge clk);
    sig(32'(irq), 1, "R7 irq after unmask");
    wr(8'h4c, 32'h01);
    pins[0] = 0; settle();

    // R12 combined output
    pins[3] = 1; pins[4] = 1; settle();
    rd(8'h40, 32'h18, "R12 two pending");
    wr(8'h4c, 32'h08);
    rd(8'h40, 32'h10, "R12 one left");
    @(negedge clk);
    sig(32'(irq), 1, "R12 irq held by remaining bit");
    wr(8'h4c, 32'h10);
    @(negedge clk);
    sig(32'(irq), 0, "R12 irq clear");
    pins[3] = 0; pins[4] = 0; settle();

    // R4 level sensitivity
    wr(8'h38, 32'h20);
    pins[5] = 1; settle();
    rd(8'h40, 32'h20, "R4 level high pending");
    wr(8'h4c, 32'h20);
    rd(8'h40, 32'h20, "R4 eoi does not clear level");
    pins[5] = 0; settle();
    rd(8'h40, 32'h00, "R4 level follows pin");
    sig(32'(irq), 0, "R4 irq follows pin");
    wr(8'h3c, 32'hDF);
    rd(8'h40, 32'h20, "R4 active-low pending");
    wr(8'h3c, 32'hFF);
    wr(8'h38, 32'h00);
    settle();

    // R10 other ports cannot interrupt
    pins[31:8] = 24'hFFFFFF; settle();
    pins[31:8] = 24'h000000; settle();
    rd(8'h40, 32'h00, "R10 other ports status");
    sig(32'(irq), 0, "R10 other ports irq");

    // R11 unmapped reads
    rd(8'h08, 0, "R11 gap 0x08");
    rd(8'h44, 0, "R11 gap 0x44");
    rd(8'h4c, 0, "R11 eoi reads zero");
    rd(8'h60, 0, "R11 beyond map");
    sig({pready, pslverr}, 32'h2, "R11 ready and no error");

    wait (act_q.size() == 0);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule